// File: doc/BRIEF.md
# PCM Voice Bus Frame Sync Generator and Detector

This block keeps frame and slot timing for a time-slotted PCM voice bus that carries 8 kHz or 16 kHz audio. Every slot is sixteen bit periods long. The number of slots per frame follows from the ratio of the bit-clock rate to the sample rate. The block runs entirely on a system clock. Two one-cycle strobes, `bit_rise` and `bit_fall`, mark the rising and falling edges of the bit clock; they come from an edge detector outside the block and are never high in the same cycle.

As bus master, the block counts bit periods into frames and drives the sync line. In long style the sync pulse covers the first three bit periods of slot 0. In short style it is a single bit period placed just before the frame begins.

As slave, the block samples the incoming sync on falling bit-clock edges and works out where slot 0 starts from the style in use. It then follows the frame on its own between pulses. It raises a loss flag when an expected pulse does not arrive.

In both roles it gives a data serializer a one-cycle frame-start strobe, the current slot index and the bit index within the slot.

The controlling state machine has five states:
- `ST_M_START`: master, waiting for the first rising edge.
- `ST_M_RUN`: master, counting frames.
- `ST_S_HUNT`: slave, with no lock.
- `ST_S_ARMED`: slave, has seen a short pulse and waits for the rising edge that opens slot 0.
- `ST_S_TRACK`: slave, locked.

Its transitions are:
- start→run on a rising edge.
- Any slave state → `ST_M_START` when the master role is selected.
- Either master state → hunt when the slave role is selected.
- hunt→armed on a short pulse, and hunt→track on a long pulse.
- armed→track on a rising edge.
- track→armed on a short pulse, and track→track (realign) on a long pulse.
- track→hunt when the loss timeout expires.

Top module: `pcm_fsync_core`

## Requirements
- R1: The frame length is 16 × 2^n bit periods, where n = `rate_code` − `fs_wide`, clamped to the range 0..4. `rate_code` k selects a bit clock of 128 kHz × 2^k, and `fs_wide`=1 selects 16 kHz audio. `slot_idx` wraps after the last slot of that frame length.
- R2: In master role, the first rising edge after reset (or after the master role is selected) starts slot 0, bit 0, and `frame_start` is high for that one cycle. Each later rising edge advances `bit_idx` by one. After bit 15, `bit_idx` returns to 0 and `slot_idx` increments. Wrapping back to slot 0 pulses `frame_start` again.
- R3: In master role with `sync_long`=1, `sync_out` is high for exactly bit periods 0, 1 and 2 of slot 0. It changes only on rising edges.
- R4: In master role with `sync_long`=0, `sync_out` is high for exactly the final bit period of each frame, that is, the last bit of the last slot.
- R5: In slave role with short style, a falling edge that samples `sync_in` high, after a falling-edge sample that was low, makes the next rising edge start slot 0, bit 0, with `frame_start`.
- R6: In slave role with long style, the first falling edge that samples `sync_in` high after a low sample sets slot 0, bit 0, and `frame_start` at that falling edge. Later high samples of the same pulse do not realign the count.
- R7: In slave role, once aligned, the indices advance by one bit on each rising edge, with the same wrap as R1, until the next pulse.
- R8: In slave role, if frame length + 1 rising edges pass with no pulse detected, `lost_sync` rises and both indices read 0. `frame_start` then stays low until a new pulse aligns the frame, and that `frame_start` clears `lost_sync`.
- R9: In slave role, `sync_out` stays low. Before the first pulse, both indices read 0 and `frame_start` stays low.
- R10: After reset, `frame_start`, `sync_out` and `lost_sync` are low and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_rise | input | 1 | One-cycle strobe at each bit-clock rising edge |
| bit_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| role_master | input | 1 | 1: drive the sync line (master); 0: follow an incoming sync (slave) |
| sync_long | input | 1 | 1: three-bit pulse aligned with the frame; 0: one-bit pulse before the frame |
| fs_wide | input | 1 | 1: 16 kHz audio; 0: 8 kHz audio |
| rate_code | input | 3 | Bit-clock rate code; the rate is 128 kHz × 2^code |
| sync_in | input | 1 | Incoming frame sync (used in slave role) |
| sync_out | output | 1 | Generated frame sync (master role) |
| frame_start | output | 1 | One-cycle strobe when slot 0, bit 0 begins |
| slot_idx | output | 4 | Current slot within the frame |
| bit_idx | output | 4 | Current bit within the slot |
| lost_sync | output | 1 | Slave lost its expected sync pulse |

## Verification
The hardest situation to reach from the ports is the loss timeout. It needs a slave that is already locked, at a known phase, followed by the withdrawal of exactly one expected pulse. The count of rising edges to the timeout also differs between the short style, where the pulse comes before the frame, and the long style, where the pulse lies inside it.

The bench drives a lead-in pulse and then several whole frames at randomly chosen rates and styles. It leaves out the pulse of the final frame in short style, and stops after the final frame's pulse in long style. It then checks that the flag is still low one rising edge before the timeout and high on the rising edge of the timeout. Finally it feeds a fresh pulse and checks that frame-start returns and the flag clears.

// File: rtl/pcm_fsync_pkg.sv
package pcm_fsync_pkg;
    typedef enum logic [2:0] {
        ST_M_START = 3'd0,
        ST_M_RUN   = 3'd1,
        ST_S_HUNT  = 3'd2,
        ST_S_ARMED = 3'd3,
        ST_S_TRACK = 3'd4
    } fsync_state_e;
endpackage

// File: rtl/pcm_fsync_cfg.sv
// Turns the rate code and the sample-rate select into a frame length in bit periods.
module pcm_fsync_cfg #(
    parameter int SLOT_LOG2      = 4,
    parameter int MAX_SLOTS_LOG2 = 4,
    parameter int RATE_W         = 3
) (
    input  logic [RATE_W-1:0]                     rate_code,
    input  logic                                  fs_wide,
    output logic [SLOT_LOG2+MAX_SLOTS_LOG2:0]     frame_len,
    output logic [SLOT_LOG2+MAX_SLOTS_LOG2-1:0]   frame_last
);
    localparam int POS_W = SLOT_LOG2 + MAX_SLOTS_LOG2;
    localparam int LEN_W = POS_W + 1;

    always_comb begin
        int lg;
        lg = int'(rate_code) - int'(fs_wide);
        if (lg < 0)              lg = 0;
        if (lg > MAX_SLOTS_LOG2) lg = MAX_SLOTS_LOG2;
        frame_len  = LEN_W'(1) << (lg + SLOT_LOG2);
        frame_last = POS_W'(frame_len - LEN_W'(1));
    end
endmodule

// File: rtl/pcm_fsync_edge.sv
// Samples the incoming sync on falling bit-clock edges and flags a new pulse.
module pcm_fsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_fall,
    input  logic sync_in,
    output logic pulse_det
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (bit_fall) prev_q <= sync_in;
    end

    assign pulse_det = bit_fall & sync_in & ~prev_q;
endmodule

// File: rtl/pcm_fsync_watch.sv
// Counts rising edges since the last detected pulse; expires one edge past a frame.
module pcm_fsync_watch #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             bit_rise,
    input  logic [CNT_W-1:0] frame_len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || restart) cnt_q <= '0;
        else if (bit_rise && cnt_q < frame_len) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = enable & ~restart & bit_rise & (cnt_q >= frame_len);
endmodule

// File: rtl/pcm_fsync_core.sv
module pcm_fsync_core #(
    parameter int SLOT_LOG2      = 4,
    parameter int MAX_SLOTS_LOG2 = 4,
    parameter int RATE_W         = 3,
    parameter int LONG_BITS      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_rise,
    input  logic                      bit_fall,
    input  logic                      role_master,
    input  logic                      sync_long,
    input  logic                      fs_wide,
    input  logic [RATE_W-1:0]         rate_code,
    input  logic                      sync_in,
    output logic                      sync_out,
    output logic                      frame_start,
    output logic [MAX_SLOTS_LOG2-1:0] slot_idx,
    output logic [SLOT_LOG2-1:0]      bit_idx,
    output logic                      lost_sync
);
    import pcm_fsync_pkg::*;

    localparam int POS_W = SLOT_LOG2 + MAX_SLOTS_LOG2;
    localparam int LEN_W = POS_W + 1;

    fsync_state_e     state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_inc, frame_last;
    logic [LEN_W-1:0] frame_len;
    logic             sync_q, fs_q, lost_q;
    logic             pulse_det, expire, watch_en;

    pcm_fsync_cfg #(
        .SLOT_LOG2(SLOT_LOG2), .MAX_SLOTS_LOG2(MAX_SLOTS_LOG2), .RATE_W(RATE_W)
    ) i_cfg (
        .rate_code(rate_code), .fs_wide(fs_wide),
        .frame_len(frame_len), .frame_last(frame_last)
    );

    pcm_fsync_edge i_edge (
        .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall),
        .sync_in(sync_in), .pulse_det(pulse_det)
    );

    assign watch_en = (state_q == ST_S_ARMED) || (state_q == ST_S_TRACK);

    pcm_fsync_watch #(.CNT_W(LEN_W)) i_watch (
        .clk(clk), .rst_n(rst_n), .enable(watch_en), .restart(pulse_det),
        .bit_rise(bit_rise), .frame_len(frame_len), .expire(expire)
    );

    assign pos_inc = (pos_q >= frame_last) ? '0 : pos_q + 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_M_START: begin
                if (!role_master)  state_d = ST_S_HUNT;
                else if (bit_rise) state_d = ST_M_RUN;
            end
            ST_M_RUN: begin
                if (!role_master) state_d = ST_S_HUNT;
            end
            ST_S_HUNT: begin
                if (role_master)    state_d = ST_M_START;
                else if (pulse_det) state_d = sync_long ? ST_S_TRACK : ST_S_ARMED;
            end
            ST_S_ARMED: begin
                if (role_master)   state_d = ST_M_START;
                else if (bit_rise) state_d = ST_S_TRACK;
            end
            ST_S_TRACK: begin
                if (role_master)    state_d = ST_M_START;
                else if (expire)    state_d = ST_S_HUNT;
                else if (pulse_det) state_d = sync_long ? ST_S_TRACK : ST_S_ARMED;
            end
            default: state_d = ST_S_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_M_START;
        else        state_q <= role_master ? state_d :
                               ((state_q == ST_M_START) ? ST_S_HUNT : state_d);
    end

    // Output and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            sync_q <= 1'b0;
            fs_q   <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            fs_q <= 1'b0;
            unique case (state_d)
                ST_M_START: begin
                    pos_q  <= '0;
                    sync_q <= 1'b0;
                    lost_q <= 1'b0;
                end
                ST_M_RUN: begin
                    lost_q <= 1'b0;
                    if (state_q == ST_M_START) begin
                        pos_q  <= '0;
                        fs_q   <= 1'b1;
                        sync_q <= sync_long;
                    end else if (bit_rise) begin
                        pos_q  <= pos_inc;
                        fs_q   <= (pos_inc == '0);
                        sync_q <= sync_long ? (pos_inc < POS_W'(LONG_BITS))
                                            : (pos_inc == frame_last);
                    end
                end
                ST_S_HUNT: begin
                    pos_q  <= '0;
                    sync_q <= 1'b0;
                    if (expire) lost_q <= 1'b1;
                end
                ST_S_ARMED: begin
                    sync_q <= 1'b0;
                end
                ST_S_TRACK: begin
                    sync_q <= 1'b0;
                    if (state_q == ST_S_ARMED || pulse_det) begin
                        pos_q  <= '0;
                        fs_q   <= 1'b1;
                        lost_q <= 1'b0;
                    end else if (bit_rise) begin
                        pos_q <= pos_inc;
                    end
                end
                default: begin
                    pos_q  <= '0;
                    sync_q <= 1'b0;
                end
            endcase
        end
    end

    assign sync_out    = sync_q;
    assign frame_start = fs_q;
    assign lost_sync   = lost_q;
    assign slot_idx    = pos_q[POS_W-1:SLOT_LOG2];
    assign bit_idx     = pos_q[SLOT_LOG2-1:0];
endmodule

// File: rtl/pcm_fsync_chk.sv
module pcm_fsync_chk #(
    parameter int SLOT_W = 4,
    parameter int BIT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_rise,
    input logic              bit_fall,
    input logic              role_master,
    input logic              sync_long,
    input logic              sync_out,
    input logic              frame_start,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [BIT_W-1:0]  bit_idx,
    input logic              lost_sync
);
    p_fs_at_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_idx == '0 && bit_idx == '0));

    p_fs_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(bit_rise || bit_fall));

    p_lost_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_sync |-> (!frame_start && slot_idx == '0 && bit_idx == '0));

    p_slave_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_master && $past(!role_master)) |-> !sync_out);

    p_long_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && sync_long && $stable(sync_long) && sync_out)
            |-> (slot_idx == '0 && bit_idx < BIT_W'(3)));

    p_short_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && !sync_long && $stable(sync_long) && sync_out)
            |-> (bit_idx == '1));
endmodule

bind pcm_fsync_core pcm_fsync_chk #(.SLOT_W(MAX_SLOTS_LOG2), .BIT_W(SLOT_LOG2)) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .role_master(role_master), .sync_long(sync_long), .sync_out(sync_out),
    .frame_start(frame_start), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .lost_sync(lost_sync)
);

// File: tb/test_pcm_fsync_core.sv
module test_pcm_fsync_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_rise = 1'b0, bit_fall = 1'b0;
    logic       role_master = 1'b1, sync_long = 1'b0, fs_wide = 1'b0, sync_in = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic       sync_out, frame_start, lost_sync;
    logic [3:0] slot_idx, bit_idx;

    int n_run = 0, n_fail = 0;
    logic fs_r, fs_f, so_r, lost_r;
    int   pos_r, pos_f;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_fsync_core i_pcm_fsync_core (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .role_master(role_master), .sync_long(sync_long), .fs_wide(fs_wide),
        .rate_code(rate_code), .sync_in(sync_in), .sync_out(sync_out),
        .frame_start(frame_start), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .lost_sync(lost_sync)
    );

    function automatic int flen(input int code, input int wide);
        int s = code - wide;
        if (s < 0) s = 0;
        if (s > 4) s = 4;
        return 16 << s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit period: eight system clocks, rise strobe first, fall strobe mid-way
    task automatic tick(input logic s);
        @(negedge clk); bit_rise = 1'b1; sync_in = s;
        @(negedge clk); bit_rise = 1'b0;
        fs_r = frame_start; so_r = sync_out; lost_r = lost_sync; pos_r = {slot_idx, bit_idx};
        repeat (2) @(negedge clk);
        @(negedge clk); bit_fall = 1'b1;
        @(negedge clk); bit_fall = 1'b0;
        fs_f = frame_start; pos_f = {slot_idx, bit_idx};
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input logic m, input logic lng, input int code, input int wide);
        @(negedge clk);
        rst_n = 1'b0; role_master = m; sync_long = lng;
        rate_code = 3'(code); fs_wide = wide[0]; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_start == 0 && sync_out == 0 && lost_sync == 0, "R10 outputs", int'(frame_start), 0);
        chk({slot_idx, bit_idx} == 8'd0, "R10 indices", int'({slot_idx, bit_idx}), 0);
    endtask

    task automatic run_master(input logic lng, input int code, input int wide, input int nf);
        int len = flen(code, wide);
        do_reset(1'b1, lng, code, wide);
        for (int i = 0; i < nf * len; i++) begin
            int k = i % len;
            tick(1'b0);
            chk(pos_r == k, "R2 position", pos_r, k);
            chk(fs_r == (k == 0), (i == 0) ? "R2 first frame_start" : "R1 wrap frame_start", int'(fs_r), int'(k == 0));
            if (lng) chk(so_r == (k < 3), "R3 long sync", int'(so_r), int'(k < 3));
            else     chk(so_r == (k == len - 1), "R4 short sync", int'(so_r), int'(k == len - 1));
        end
        @(negedge clk); role_master = 1'b0;
        repeat (3) @(negedge clk);
        chk(sync_out == 1'b0, "R9 slave sync_out", int'(sync_out), 0);
        chk({slot_idx, bit_idx} == 8'd0, "R9 slave idle indices", int'({slot_idx, bit_idx}), 0);
    endtask

    task automatic run_slave(input logic lng, input int code, input int wide, input int nf, input int idle);
        int len = flen(code, wide);
        do_reset(1'b0, lng, code, wide);
        for (int i = 0; i < idle; i++) begin
            tick(1'b0);
            chk(fs_r == 0 && fs_f == 0 && pos_r == 0, "R9 no frame before pulse", pos_r, 0);
            chk(so_r == 0, "R9 slave sync_out", int'(so_r), 0);
        end
        if (!lng) tick(1'b1);
        for (int f = 0; f < nf; f++) begin
            for (int k = 0; k < len; k++) begin
                logic s = lng ? (k < 3) : (k == len - 1 && f < nf - 1);
                tick(s);
                chk(pos_r == k, "R7 slave position", pos_r, k);
                if (lng) begin
                    chk(fs_f == (k == 0) && fs_r == 0, "R6 long frame_start", int'(fs_f), int'(k == 0));
                    if (k == 0) chk(pos_f == 0, "R6 aligned at fall", pos_f, 0);
                end else begin
                    chk(fs_r == (k == 0) && fs_f == 0, "R5 short frame_start", int'(fs_r), int'(k == 0));
                end
                chk(lost_r == 0, "R8 no early loss", int'(lost_r), 0);
            end
        end
        if (lng) begin
            tick(1'b0);
            chk(lost_r == 0, "R8 loss one edge early", int'(lost_r), 0);
        end
        tick(1'b0);
        chk(lost_r == 1, "R8 loss raised", int'(lost_r), 1);
        chk(pos_r == 0 && fs_r == 0 && fs_f == 0, "R8 indices held", pos_r, 0);
        for (int i = 0; i < 3; i++) begin
            tick(1'b0);
            chk(lost_r == 1 && fs_r == 0 && fs_f == 0, "R8 stays lost", int'(lost_r), 1);
        end
        if (lng) begin
            tick(1'b1);
            chk(fs_f == 1, "R8 realign long", int'(fs_f), 1);
            tick(1'b1);
            chk(lost_r == 0 && pos_r == 1, "R8 loss cleared", pos_r, 1);
            tick(1'b1);
            chk(fs_f == 0 && pos_f == 2, "R6 no retrigger", pos_f, 2);
        end else begin
            tick(1'b1);
            tick(1'b0);
            chk(fs_r == 1 && lost_r == 0, "R8 realign short", int'(fs_r), 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        run_master(1'b0, 0, 0, 2);
        run_master(1'b1, 4, 0, 2);
        run_master(1'b1, 0, 1, 3);
        run_slave(1'b0, 4, 1, 3, 5);
        run_slave(1'b1, 1, 0, 3, 2);
        run_slave(1'b1, 0, 0, 3, 0);
        // random configurations
        for (int r = 0; r < 3; r++) begin
            run_master(1'($urandom_range(0, 1)), $urandom_range(0, 4), $urandom_range(0, 1), 2);
            run_slave(1'($urandom_range(0, 1)), $urandom_range(0, 4), $urandom_range(0, 1), 3,
                      $urandom_range(0, 12));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule